// File: doc/BRIEF.md
# Configuration Image Sync Locator

This block sits in front of a configuration loader and receives a byte stream that holds one configuration image file per packet, with the final byte marked by a last flag. It throws away the file's header and any bytes ahead of the synchronisation preamble. It hands only the configuration payload to a downstream consumer, over a valid/ready byte interface that carries the same last marker.

Two image formats are supported. A mode input selects the format, and the block reads it once per image. In raw mode the block walks a header made of a fixed prefix and four length-prefixed fields. It then looks for a run of four 0xFF bytes and forwards the stream starting with that run. In compressed mode the block ignores the header layout and scans from the very first byte for a 0xFF byte followed by a byte in the range 0x30..0x3F. It forwards only the bytes after that pair. A sticky found or error flag reports the outcome of each image.

Top module: `img_sync_locator`

## Requirements
- R1: While reset is held and right after it, out_valid, found and error are 0 and in_ready is 1.
- R2: With mode_raw=0, the preamble is a byte equal to 0xFF immediately followed by a byte whose bits [7:4] equal 4'h3. The search starts at image byte 0, and a run of several 0xFF bytes before the nibble byte still matches. The first byte forwarded is the byte right after the nibble byte.
- R3: With mode_raw=1, bytes 0..14 are discarded and byte 15 holds a length L. The next length byte sits L+3 bytes further on, and exactly four such fields are skipped. No header byte takes part in the preamble search, including header bytes equal to 0xFF.
- R4: With mode_raw=1, the preamble is the first run of four consecutive 0xFF bytes after the header. These four bytes are the first four bytes forwarded, and the rest of the image follows them. A run longer than four matches at its first four bytes.
- R5: Forwarded bytes keep their input order, none is dropped or repeated, and out_last is 1 on exactly the forwarded copy of the image's final byte.
- R6: If the final byte of an image is accepted before a preamble is found, error becomes 1 and nothing of that image is forwarded.
- R7: found becomes 1 when the preamble is accepted. found and error both hold until the first byte of the next image is accepted, and both clear at that point. found and error are never 1 together.
- R8: While out_valid is 1 and out_ready is 0, out_data and out_last stay unchanged and no input byte is lost.
- R9: mode_raw is sampled when the first byte of an image is accepted. Changes to mode_raw later in the same image have no effect.
- R10: In compressed mode, a preamble whose nibble byte is the image's final byte sets found and forwards nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_raw | input | 1 | 1 = raw format, 0 = compressed format (sampled per image) |
| in_data | input | 8 | Image byte |
| in_valid | input | 1 | Input byte valid |
| in_last | input | 1 | Input byte is the image's final byte |
| in_ready | output | 1 | Block accepts the input byte |
| out_data | output | 8 | Forwarded payload byte |
| out_valid | output | 1 | Output byte valid |
| out_last | output | 1 | Output byte is the image's final byte |
| out_ready | input | 1 | Consumer accepts the output byte |
| found | output | 1 | Preamble located in the current or most recent image |
| error | output | 1 | Most recent image ended without a preamble |

## Verification
The assertions check four things on every cycle: that found and error are mutually exclusive, that a stalled output byte stays stable, that no byte is presented while error is set, and that no byte goes out before found. Which bytes are payload depends on the header lengths, on overlapping 0xFF runs and on the per-image mode sample. Only the bench's scenarios can show these: its reference model replays each image and compares every accepted output byte under random gaps and backpressure.

// File: rtl/img_sync_pkg.sv
package img_sync_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_SRCH,
    ST_PRE,
    ST_PASS
  } sync_state_e;

  localparam logic [7:0] SYNC_BYTE = 8'hFF;
  localparam logic [3:0] CMP_NIB   = 4'h3;

endpackage

// File: rtl/img_hdr_walk.sv
module img_hdr_walk #(
  parameter int POS_W    = 16,
  parameter int HDR_OFS  = 15,
  parameter int N_FIELDS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       step,
  input  logic [7:0] byte_in,
  output logic       hdr_end
);

  localparam int FLD_W = $clog2(N_FIELDS + 1);

  logic [POS_W-1:0] pos_q, pos_d;
  logic [POS_W-1:0] nxt_q, nxt_d;
  logic [FLD_W-1:0] fld_q, fld_d;

  always_comb begin
    pos_d = pos_q;
    nxt_d = nxt_q;
    fld_d = fld_q;
    if (clr) begin
      pos_d = '0;
      nxt_d = POS_W'(HDR_OFS);
      fld_d = '0;
    end else if (step) begin
      pos_d = pos_q + POS_W'(1);
      if ((pos_q == nxt_q) && (fld_q != FLD_W'(N_FIELDS))) begin
        nxt_d = nxt_q + POS_W'(byte_in) + POS_W'(3);
        fld_d = fld_q + FLD_W'(1);
      end
    end
  end

  // current byte is the final header byte: all fields counted and the
  // next position is the first searchable one
  assign hdr_end = (fld_q == FLD_W'(N_FIELDS)) && ((pos_q + POS_W'(1)) == nxt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      nxt_q <= POS_W'(HDR_OFS);
      fld_q <= '0;
    end else begin
      pos_q <= pos_d;
      nxt_q <= nxt_d;
      fld_q <= fld_d;
    end
  end

endmodule

// File: rtl/img_sync_match.sv
module img_sync_match
  import img_sync_pkg::*;
#(
  parameter int RUN_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       step,
  input  logic       raw,
  input  logic [7:0] byte_in,
  output logic       hit
);

  localparam int RUN_W = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1;
  localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(RUN_LEN - 1);

  logic [RUN_W-1:0] run_q, run_d;
  logic             is_sync;

  assign is_sync = (byte_in == SYNC_BYTE);

  // raw: completes a run of RUN_LEN sync bytes
  // compressed: sync byte seen just before and nibble matches now
  assign hit = raw ? (is_sync && (run_q == RUN_TOP))
                   : ((run_q != '0) && (byte_in[7:4] == CMP_NIB));

  always_comb begin
    run_d = run_q;
    if (clr) begin
      run_d = '0;
    end else if (step) begin
      if (!is_sync)                run_d = '0;
      else if (run_q != RUN_TOP)   run_d = run_q + RUN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

endmodule

// File: rtl/img_sync_locator.sv
module img_sync_locator
  import img_sync_pkg::*;
#(
  parameter int POS_W    = 16,
  parameter int HDR_OFS  = 15,
  parameter int N_FIELDS = 4,
  parameter int RUN_LEN  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_raw,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_last,
  output logic       in_ready,
  output logic [7:0] out_data,
  output logic       out_valid,
  output logic       out_last,
  input  logic       out_ready,
  output logic       found,
  output logic       error
);

  localparam int CNT_W = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1;

  sync_state_e      st_q, st_d;
  logic             raw_q, raw_d;
  logic             found_q, found_d;
  logic             err_q, err_d;
  logic [CNT_W-1:0] pre_cnt_q, pre_cnt_d;
  logic             pre_last_q, pre_last_d;

  logic acc_in, acc_out, raw_cur, hdr_ph, srch_ph, clr, hdr_end, hit;

  assign acc_in  = in_valid && in_ready;
  assign acc_out = out_valid && out_ready;
  assign raw_cur = (st_q == ST_IDLE) ? mode_raw : raw_q;
  assign hdr_ph  = (st_q == ST_HDR)  || ((st_q == ST_IDLE) && mode_raw);
  assign srch_ph = (st_q == ST_SRCH) || ((st_q == ST_IDLE) && !mode_raw);
  assign clr     = acc_in && in_last;

  img_hdr_walk #(
    .POS_W   (POS_W),
    .HDR_OFS (HDR_OFS),
    .N_FIELDS(N_FIELDS)
  ) u_hdr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .step   (acc_in && hdr_ph),
    .byte_in(in_data),
    .hdr_end(hdr_end)
  );

  img_sync_match #(
    .RUN_LEN(RUN_LEN)
  ) u_match (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .step   (acc_in && srch_ph),
    .raw    (raw_cur),
    .byte_in(in_data),
    .hit    (hit)
  );

  // handshake and output mux
  always_comb begin
    in_ready  = 1'b1;
    out_valid = 1'b0;
    out_data  = '0;
    out_last  = 1'b0;
    case (st_q)
      ST_PRE: begin
        in_ready  = 1'b0;
        out_valid = 1'b1;
        out_data  = SYNC_BYTE;
        out_last  = pre_last_q && (pre_cnt_q == '0);
      end
      ST_PASS: begin
        in_ready  = out_ready;
        out_valid = in_valid;
        out_data  = in_data;
        out_last  = in_last;
      end
      default: ;
    endcase
  end

  // next state
  always_comb begin
    st_d       = st_q;
    raw_d      = raw_q;
    found_d    = found_q;
    err_d      = err_q;
    pre_cnt_d  = pre_cnt_q;
    pre_last_d = pre_last_q;
    case (st_q)
      ST_IDLE, ST_HDR, ST_SRCH: begin
        if (acc_in) begin
          if (st_q == ST_IDLE) begin
            raw_d   = mode_raw;
            found_d = 1'b0;
            err_d   = 1'b0;
          end
          if (srch_ph && hit) begin
            found_d = 1'b1;
            if (raw_cur) begin
              st_d       = ST_PRE;
              pre_cnt_d  = CNT_W'(RUN_LEN - 1);
              pre_last_d = in_last;
            end else begin
              st_d = in_last ? ST_IDLE : ST_PASS;
            end
          end else if (in_last) begin
            err_d = 1'b1;
            st_d  = ST_IDLE;
          end else if (hdr_ph) begin
            st_d = hdr_end ? ST_SRCH : ST_HDR;
          end else begin
            st_d = ST_SRCH;
          end
        end
      end
      ST_PRE: begin
        if (acc_out) begin
          if (pre_cnt_q == '0) st_d = pre_last_q ? ST_IDLE : ST_PASS;
          else                 pre_cnt_d = pre_cnt_q - CNT_W'(1);
        end
      end
      ST_PASS: begin
        if (acc_in && in_last) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      raw_q      <= 1'b0;
      found_q    <= 1'b0;
      err_q      <= 1'b0;
      pre_cnt_q  <= '0;
      pre_last_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      raw_q      <= raw_d;
      found_q    <= found_d;
      err_q      <= err_d;
      pre_cnt_q  <= pre_cnt_d;
      pre_last_q <= pre_last_d;
    end
  end

  assign found = found_q;
  assign error = err_q;

endmodule

// File: rtl/img_sync_chk.sv
module img_sync_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] out_data,
  input logic       out_valid,
  input logic       out_last,
  input logic       out_ready,
  input logic       found,
  input logic       error
);

  // R7
  found_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(found && error));

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R6
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !out_valid);

  // R2 R4
  fwd_after_found_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> found);

endmodule

bind img_sync_locator img_sync_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .out_data (out_data),
  .out_valid(out_valid),
  .out_last (out_last),
  .out_ready(out_ready),
  .found    (found),
  .error    (error)
);

// File: tb/sim_img_sync_locator.sv
`timescale 1ns/1ps
module sim_img_sync_locator;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_raw;
  logic [7:0] in_data;
  logic       in_valid;
  logic       in_last;
  logic       in_ready;
  logic [7:0] out_data;
  logic       out_valid;
  logic       out_last;
  logic       out_ready;
  logic       found;
  logic       error;

  int n_cmp = 0;
  int n_bad = 0;
  bit done_flag = 0;
  bit bp_en = 0;

  logic [7:0] img[$];
  logic [8:0] exp_q[$];
  bit         exp_found, exp_err;

  always #2.5 clk = ~clk;

  img_sync_locator u0 (
    .clk(clk), .rst_n(rst_n), .mode_raw(mode_raw),
    .in_data(in_data), .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_last(out_last), .out_ready(out_ready),
    .found(found), .error(error)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock output comparison against the reference queue (R5, R8)
  logic       stall_seen = 0;
  logic [8:0] stall_val;
  always @(negedge clk) begin
    out_ready = bp_en ? (($urandom % 4) != 0) : 1'b1;
    #1;
    if (rst_n) begin
      if (stall_seen)
        check(out_valid && ({out_last, out_data} == stall_val), "R8 held output",
              {out_valid, out_last, out_data}, {1'b1, stall_val});
      stall_seen = 0;
      if (out_valid && !out_ready) begin
        stall_seen = 1;
        stall_val  = {out_last, out_data};
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(0, "R5 unexpected byte", {out_last, out_data}, 0);
        else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          check({out_last, out_data} == e, "R5 forwarded byte", {out_last, out_data}, e);
        end
      end
    end
  end

  task automatic send_byte(input logic [7:0] b, input bit last);
    bit ok;
    @(negedge clk);
    if (($urandom % 3) == 0) begin
      in_valid = 0;
      @(negedge clk);
    end
    in_valid = 1; in_data = b; in_last = last;
    forever begin
      #1; ok = in_ready;
      @(posedge clk);
      if (ok) break;
      @(negedge clk);
    end
    #0.5 in_valid = 0;
  endtask

  // reference: compute expected payload and status from the requirements
  task automatic model(input bit raw);
    int n, idx, start;
    n = img.size();
    start = -1;
    if (raw) begin
      bit ovr;
      ovr = 0; idx = 15;
      for (int k = 0; k < 4; k++) begin
        if (idx >= n) begin ovr = 1; break; end
        idx = idx + int'(img[idx]) + 3;
      end
      if (!ovr)
        for (int i = idx; i + 3 < n; i++)
          if (img[i] == 8'hFF && img[i+1] == 8'hFF && img[i+2] == 8'hFF && img[i+3] == 8'hFF) begin
            start = i; break;
          end
      exp_found = (start >= 0);
    end else begin
      for (int i = 0; i + 1 < n; i++)
        if (img[i] == 8'hFF && img[i+1][7:4] == 4'h3) begin start = i + 2; break; end
      exp_found = (start >= 0);
    end
    exp_err = !exp_found;
    if (exp_found)
      for (int i = start; i < n; i++) exp_q.push_back({(i == n - 1), img[i]});
  endtask

  task automatic run_image(input bit raw, input bit flip, input string tag);
    int n, w;
    n = img.size();
    @(negedge clk);
    mode_raw = raw;
    model(raw);
    for (int i = 0; i < n; i++) begin
      send_byte(img[i], i == n - 1);
      if (i == 0) begin
        if (flip) mode_raw = ~raw;
        if (n > 1) begin
          @(negedge clk); #1;
          check(!found && !error, {"R7 status cleared ", tag}, {found, error}, 0);
        end
      end
    end
    w = 0;
    while (exp_q.size() != 0 && w < 1000) begin @(negedge clk); w++; end
    repeat (3) @(negedge clk);
    #1;
    check(exp_q.size() == 0, {"R5 all bytes out ", tag}, exp_q.size(), 0);
    check(found == exp_found, {"R7 found ", tag}, found, exp_found);
    check(error == exp_err, {"R6 error ", tag}, error, exp_err);
    exp_q.delete();
    img.delete();
  endtask

  task automatic push_n(input int cnt, input logic [7:0] v);
    for (int i = 0; i < cnt; i++) img.push_back(v);
  endtask

  // R3 header: 15 prefix bytes then four fields of (L, L+2 filler bytes)
  task automatic add_hdr(input logic [7:0] fill, input int l0, input int l1, input int l2, input int l3);
    int ls[4];
    ls = '{l0, l1, l2, l3};
    push_n(15, fill);
    for (int k = 0; k < 4; k++) begin
      img.push_back(8'(ls[k]));
      push_n(ls[k] + 2, fill);
    end
  endtask

  task automatic add_data(input int cnt, input logic [7:0] seed);
    for (int i = 0; i < cnt; i++) img.push_back(8'(seed + 8'(i * 7)));
  endtask

  initial begin
    #(5 * 150000);
    if (!done_flag) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; in_valid = 0; in_data = 0; in_last = 0; mode_raw = 0; out_ready = 1;
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid && !found && !error && in_ready, "R1 reset state",
          {out_valid, found, error, in_ready}, 4'b0001);
    @(negedge clk); rst_n = 1;
    @(negedge clk); #1;
    check(!out_valid && !found && !error && in_ready, "R1 after release",
          {out_valid, found, error, in_ready}, 4'b0001);

    // R2 basic compressed
    for (int i = 0; i < 10; i++) img.push_back(8'(8'h11 * i));
    img.push_back(8'hFF); img.push_back(8'h37);
    add_data(12, 8'h40); img.push_back(8'hFF); img.push_back(8'h35);
    run_image(0, 0, "R2 basic");

    // R2 overlap and near misses
    bp_en = 1;
    img.push_back(8'h00); img.push_back(8'hFF); img.push_back(8'h20);
    img.push_back(8'hFF); img.push_back(8'hFF); img.push_back(8'h3A);
    add_data(8, 8'h05);
    run_image(0, 0, "R2 overlap");

    // R2 match at image start, ignoring any header layout
    img.push_back(8'hFF); img.push_back(8'h31); add_data(20, 8'h90);
    run_image(0, 0, "R2 at byte0");

    // R6 compressed without preamble
    img.push_back(8'hFF); img.push_back(8'h40); img.push_back(8'hFF); img.push_back(8'h2F);
    add_data(10, 8'h01); img.push_back(8'hFF);
    run_image(0, 0, "R6 cmp none");

    // R10 compressed match on final byte
    img.push_back(8'h01); img.push_back(8'hFF); img.push_back(8'h30);
    run_image(0, 0, "R10 end match");

    // R3 R4 raw basic
    add_hdr(8'h00, 2, 0, 5, 1);
    img.push_back(8'h01); img.push_back(8'h02);
    push_n(4, 8'hFF); add_data(10, 8'h21);
    run_image(1, 0, "R4 basic");

    // R3 header of 0xFF bytes ignored; R4 run of five matches at first four
    add_hdr(8'hFF, 3, 1, 0, 2);
    img.push_back(8'hFF); img.push_back(8'hFF); img.push_back(8'h00);
    push_n(5, 8'hFF); img.push_back(8'h55); img.push_back(8'h66);
    run_image(1, 0, "R3 ff header");

    // R3 large length and compressed-style pair in body ignored in raw
    add_hdr(8'hA5, 40, 7, 0, 200);
    img.push_back(8'hFF); img.push_back(8'h33);
    push_n(4, 8'hFF); add_data(6, 8'h77);
    run_image(1, 0, "R3 long field");

    // R6 raw without preamble, and truncated header
    add_hdr(8'h10, 1, 1, 1, 1);
    push_n(3, 8'hFF); img.push_back(8'h00); push_n(3, 8'hFF);
    run_image(1, 0, "R6 raw none");
    push_n(15, 8'hFF); img.push_back(8'd30); push_n(6, 8'hFF);
    run_image(1, 0, "R6 raw trunc");

    // R4 R5 preamble is the final four bytes
    add_hdr(8'h00, 0, 0, 0, 0);
    img.push_back(8'h00); push_n(4, 8'hFF);
    run_image(1, 0, "R4 end run");

    // R9 mode flipped after first byte, both directions
    add_hdr(8'h00, 1, 2, 3, 4);
    img.push_back(8'hFF); img.push_back(8'h34);
    push_n(4, 8'hFF); add_data(5, 8'hC0);
    run_image(1, 1, "R9 raw held");
    img.push_back(8'h00); push_n(4, 8'hFF); img.push_back(8'h3C); add_data(5, 8'hD0);
    run_image(0, 1, "R9 cmp held");

    done_flag = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule